// File: doc/BRIEF.md
# Shift-Gain Proportional-Integral Loop Filter

This block turns a stream of signed frequency-error samples into a frequency correction word for a downconverter's tracking loop. Each error sample takes two paths. The proportional path scales the sample directly. The integral path scales the sample and adds it into a running accumulator. The output is the sum of the two paths. Both gains are powers of two and are applied by arithmetic left shift, so the block needs no multiplier.

Each path can be switched on or off on its own. With only the proportional path on, the loop is first order. With both paths on, it is second order. With only the integral path on, the filter is a pure integrator. The accumulator and the output saturate at the limits of the signed word instead of wrapping, so a large or persistent error cannot flip the sign of the correction. A clear input empties the accumulator so the loop can restart from zero.

Top module: `pi_shift_loop_filter`

## Requirements
- R1: A synchronous active-high reset sets the correction output and the integral accumulator to zero.
- R2: When the proportional enable is high, the proportional term is the error sample (8-bit two's complement) multiplied by 2 raised to the proportional exponent.
- R3: On each valid sample with the integral enable high, the scaled sample (error times 2 raised to the integral exponent) is added to the accumulator. The output includes this updated accumulator value in the same update.
- R4: An exponent value above 21 on either 5-bit exponent input acts exactly like 21.
- R5: A disabled path contributes zero to the output. With both paths disabled, a valid sample drives the output to zero.
- R6: While the integral enable is low, the accumulator keeps its value. When the enable returns, accumulation continues from that kept value.
- R7: The clear input sets the accumulator to zero at the next clock edge. Clear takes priority over an accumulation in the same cycle, and the output formed in that cycle uses zero for the integral term.
- R8: The 32-bit signed accumulator saturates at +2147483647 and -2147483648 instead of wrapping.
- R9: The output is the sum of the two path terms, saturated to the 32-bit signed range.
- R10: The output changes only on the clock edge that registers a valid sample, one clock after that sample is presented. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr_int | input | 1 | Clears the integral accumulator |
| err_valid | input | 1 | Marks err_in as a new sample |
| err_in | input | 8 | Signed frequency error sample |
| kp_en | input | 1 | Enables the proportional path |
| ki_en | input | 1 | Enables the integral path |
| kp_exp | input | 5 | Proportional gain exponent (values above 21 act as 21) |
| ki_exp | input | 5 | Integral gain exponent (values above 21 act as 21) |
| corr_out | output | 32 | Signed frequency correction word |

## Verification
The bench drives the accumulator into both saturation limits, using +127 and -128 at the largest shift. A design that wrapped instead of saturating would show a sudden sign reversal at the output. It also applies exponents from 22 to 31. A design that skipped the limit would shift too far, or wrap the shift amount, and give a scaled value that is wrong by orders of magnitude. Other directed steps do three things: they turn the integral path off and back on, which exposes a design that leaks samples into a disabled accumulator or zeroes it; they assert clear together with a valid sample, which exposes wrong priority; and they apply cycles with no valid sample, which expose an output that moves without a new sample. A long random run with a fixed seed then compares every output against a bench model.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
    localparam int unsigned LPF_ERR_W   = 8;
    localparam int unsigned LPF_EXP_W   = 5;
    localparam int unsigned LPF_MAX_EXP = 21;
    localparam int unsigned LPF_WORD_W  = 32;

    typedef enum logic [1:0] {
        PATHS_NONE = 2'b00,
        PATHS_P    = 2'b01,
        PATHS_I    = 2'b10,
        PATHS_PI   = 2'b11
    } path_sel_e;
endpackage

// File: rtl/lpf_shift_gain.sv
module lpf_shift_gain #(
    parameter int unsigned IN_W    = 8,
    parameter int unsigned EXP_W   = 5,
    parameter int unsigned MAX_EXP = 21,
    parameter int unsigned OUT_W   = 32
) (
    input  logic                    enable,
    input  logic signed [IN_W-1:0]  sample,
    input  logic [EXP_W-1:0]        exp_in,
    output logic signed [OUT_W-1:0] term
);
    localparam int unsigned EXP_TOP = (1 << EXP_W) - 1;

    logic [EXP_W-1:0]        exp_eff;
    logic signed [OUT_W-1:0] widened;

    generate
        if (EXP_TOP > MAX_EXP) begin : g_limit
            always_comb begin
                exp_eff = exp_in;
                if (exp_in > EXP_W'(MAX_EXP)) begin
                    exp_eff = EXP_W'(MAX_EXP);
                end
            end
        end else begin : g_nolimit
            always_comb exp_eff = exp_in;
        end
    endgenerate

    always_comb begin
        widened = {{(OUT_W-IN_W){sample[IN_W-1]}}, sample};
        term    = enable ? (widened <<< exp_eff) : '0;
    end
endmodule

// File: rtl/lpf_sat_add.sv
module lpf_sat_add #(
    parameter int unsigned W = 32
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    logic signed [W:0] wide_sum;

    always_comb begin
        wide_sum = {a[W-1], a} + {b[W-1], b};
        if (wide_sum[W] != wide_sum[W-1]) begin
            y = {wide_sum[W], {(W-1){~wide_sum[W]}}};
        end else begin
            y = wide_sum[W-1:0];
        end
    end
endmodule

// File: rtl/pi_shift_loop_filter.sv
module pi_shift_loop_filter
    import lpf_pkg::*;
#(
    parameter int unsigned ERR_W   = LPF_ERR_W,
    parameter int unsigned EXP_W   = LPF_EXP_W,
    parameter int unsigned MAX_EXP = LPF_MAX_EXP,
    parameter int unsigned WORD_W  = LPF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_int,
    input  logic              err_valid,
    input  logic [ERR_W-1:0]  err_in,
    input  logic              kp_en,
    input  logic              ki_en,
    input  logic [EXP_W-1:0]  kp_exp,
    input  logic [EXP_W-1:0]  ki_exp,
    output logic [WORD_W-1:0] corr_out
);
    typedef struct packed {
        logic signed [WORD_W-1:0] acc;
        logic signed [WORD_W-1:0] out;
    } lpf_state_t;

    lpf_state_t state_d, state_q;

    logic signed [WORD_W-1:0] p_term;
    logic signed [WORD_W-1:0] i_term;
    logic signed [WORD_W-1:0] acc_sum;
    logic signed [WORD_W-1:0] acc_next;
    logic signed [WORD_W-1:0] i_contrib;
    logic signed [WORD_W-1:0] out_sum;
    logic signed [WORD_W-1:0] acc_q;
    path_sel_e                paths;

    assign paths = path_sel_e'({ki_en, kp_en});

    lpf_shift_gain #(
        .IN_W(ERR_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .OUT_W(WORD_W)
    ) u_gain_p (
        .enable (paths == PATHS_P || paths == PATHS_PI),
        .sample (err_in),
        .exp_in (kp_exp),
        .term   (p_term)
    );

    lpf_shift_gain #(
        .IN_W(ERR_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP), .OUT_W(WORD_W)
    ) u_gain_i (
        .enable (paths == PATHS_I || paths == PATHS_PI),
        .sample (err_in),
        .exp_in (ki_exp),
        .term   (i_term)
    );

    lpf_sat_add #(.W(WORD_W)) u_acc_add (
        .a (state_q.acc),
        .b (i_term),
        .y (acc_sum)
    );

    // Accumulator next value: clear wins, then accumulate on an enabled sample
    always_comb begin
        if (clr_int) begin
            acc_next = '0;
        end else if (err_valid && ki_en) begin
            acc_next = acc_sum;
        end else begin
            acc_next = state_q.acc;
        end
        i_contrib = ki_en ? acc_next : '0;
    end

    lpf_sat_add #(.W(WORD_W)) u_out_add (
        .a (p_term),
        .b (i_contrib),
        .y (out_sum)
    );

    always_comb begin
        state_d     = state_q;
        state_d.acc = acc_next;
        if (err_valid) begin
            state_d.out = out_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc_q    = state_q.acc;
    assign corr_out = state_q.out;
endmodule

// File: rtl/pi_shift_loop_filter_chk.sv
module pi_shift_loop_filter_chk #(
    parameter int unsigned ERR_W  = 8,
    parameter int unsigned WORD_W = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     clr_int,
    input logic                     err_valid,
    input logic [ERR_W-1:0]         err_in,
    input logic                     kp_en,
    input logic                     ki_en,
    input logic signed [WORD_W-1:0] corr_out,
    input logic signed [WORD_W-1:0] acc_q
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (corr_out == '0) && (acc_q == '0));

    a_r10_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
        !err_valid |=> $stable(corr_out));

    a_r6_acc_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!ki_en && !clr_int) |=> $stable(acc_q));

    a_r7_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        clr_int |=> (acc_q == '0));

    a_r5_both_paths_off: assert property (@(posedge clk) disable iff (rst)
        (err_valid && !kp_en && !ki_en) |=> (corr_out == '0));

    a_r8_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
        (err_valid && ki_en && !clr_int && !err_in[ERR_W-1]) |=> (acc_q >= $past(acc_q)));

    a_r8_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (err_valid && ki_en && !clr_int && err_in[ERR_W-1]) |=> (acc_q <= $past(acc_q)));
endmodule

bind pi_shift_loop_filter pi_shift_loop_filter_chk #(
    .ERR_W(ERR_W), .WORD_W(WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_int   (clr_int),
    .err_valid (err_valid),
    .err_in    (err_in),
    .kp_en     (kp_en),
    .ki_en     (ki_en),
    .corr_out  (corr_out),
    .acc_q     (acc_q)
);

// File: tb/pi_shift_loop_filter_tb.sv
`timescale 1ns/1ps
module pi_shift_loop_filter_tb;
    localparam longint WMAX = 64'sd2147483647;
    localparam longint WMIN = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_int = 1'b0;
    logic        err_valid = 1'b0;
    logic [7:0]  err_in = '0;
    logic        kp_en = 1'b0;
    logic        ki_en = 1'b0;
    logic [4:0]  kp_exp = '0;
    logic [4:0]  ki_exp = '0;
    logic [31:0] corr_out;

    int checks = 0;
    int failures = 0;
    longint acc_m = 0;
    longint out_m = 0;

    always #10 clk = ~clk;

    pi_shift_loop_filter u_dut (
        .clk(clk), .rst(rst), .clr_int(clr_int), .err_valid(err_valid),
        .err_in(err_in), .kp_en(kp_en), .ki_en(ki_en),
        .kp_exp(kp_exp), .ki_exp(ki_exp), .corr_out(corr_out)
    );

    function automatic longint sat32(longint v);
        if (v > WMAX) return WMAX;
        if (v < WMIN) return WMIN;
        return v;
    endfunction

    function automatic longint scaled(logic [7:0] e, logic [4:0] x);
        longint base = longint'($signed(e));
        int     sh   = (x > 5'd21) ? 21 : int'(x);
        return base * (64'sd1 <<< sh);
    endfunction

    task automatic check(string tag, longint expv);
        longint act = longint'($signed(corr_out));
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Called at a falling edge; drives, crosses one rising edge, checks at the next falling edge
    task automatic step(string tag, bit v, logic [7:0] e, bit pe, bit ie,
                        logic [4:0] px, logic [4:0] ix, bit clr);
        longint pt;
        err_valid = v; err_in = e; kp_en = pe; ki_en = ie;
        kp_exp = px; ki_exp = ix; clr_int = clr;
        pt = pe ? scaled(e, px) : 0;
        if (clr) acc_m = 0;
        else if (v && ie) acc_m = sat32(acc_m + scaled(e, ix));
        if (v) out_m = sat32(pt + (ie ? acc_m : 0));
        @(negedge clk);
        check(tag, out_m);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset output", 0);
        step("R1 reset accumulator", 1, 8'd0, 0, 1, 5'd0, 5'd0, 0);

        // R2 proportional path only, R4 exponent limit
        step("R2 p only pos",      1, 8'd5,    1, 0, 5'd3,  5'd0, 0);
        step("R2 p only neg",      1, 8'hF6,   1, 0, 5'd10, 5'd0, 0);
        step("R4 p exp 31 as 21",  1, 8'd127,  1, 0, 5'd31, 5'd0, 0);
        step("R4 p exp 22 as 21",  1, 8'h80,   1, 0, 5'd22, 5'd0, 0);
        // R10 hold without a valid sample
        step("R10 hold",           0, 8'd99,   1, 1, 5'd7,  5'd7, 0);
        step("R10 hold again",     0, 8'h81,   0, 0, 5'd1,  5'd1, 0);

        // R3 integral accumulation
        step("R3 integrate 1",     1, 8'd3,    0, 1, 5'd0,  5'd4, 0);
        step("R3 integrate 2",     1, 8'd3,    0, 1, 5'd0,  5'd4, 0);
        step("R3 integrate neg",   1, 8'hFF,   1, 1, 5'd2,  5'd4, 0);
        // R6 hold while disabled, then resume
        step("R6 ki off",          1, 8'd50,   1, 0, 5'd0,  5'd4, 0);
        step("R6 resume",          1, 8'd0,    0, 1, 5'd0,  5'd4, 0);
        // R5 both paths disabled
        step("R5 both off",        1, 8'd77,   0, 0, 5'd5,  5'd5, 0);
        step("R5 i off check",     1, 8'd1,    1, 1, 5'd0,  5'd0, 0);
        // R7 clear priority and clear without sample
        step("R7 clear with sample", 1, 8'd9,  1, 1, 5'd1,  5'd6, 1);
        step("R7 after clear",     1, 8'd0,    0, 1, 5'd0,  5'd0, 0);
        step("R7 build",           1, 8'd20,   0, 1, 5'd0,  5'd0, 0);
        step("R7 clear no sample", 0, 8'd20,   0, 1, 5'd0,  5'd0, 1);
        step("R7 cleared read",    1, 8'd0,    0, 1, 5'd0,  5'd0, 0);

        // R8 accumulator saturation both ways, R4 on the integral exponent
        for (int i = 0; i < 12; i++)
            step("R8 sat high", 1, 8'd127, 0, 1, 5'd0, 5'd25, 0);
        step("R8 leave high",      1, 8'hFF,   0, 1, 5'd0,  5'd0, 0);
        for (int i = 0; i < 20; i++)
            step("R8 sat low", 1, 8'h80, 0, 1, 5'd0, 5'd21, 0);
        step("R8 leave low",       1, 8'd1,    0, 1, 5'd0,  5'd0, 0);
        // R9 output saturation beyond the accumulator
        step("R9 out sat low",     1, 8'h80,   1, 1, 5'd21, 5'd0, 0);
        for (int i = 0; i < 20; i++)
            step("R9 fill high", 1, 8'd127, 0, 1, 5'd0, 5'd21, 0);
        step("R9 out sat high",    1, 8'd127,  1, 1, 5'd21, 5'd0, 0);
        step("R7 clear final",     1, 8'd0,    1, 1, 5'd0,  5'd0, 1);

        // Random run: R2 R3 R4 R5 R6 R7 R8 R9 R10 against the model
        for (int i = 0; i < 4000; i++) begin
            step("R10 random",
                 ($urandom % 4) != 0,
                 8'($urandom),
                 ($urandom % 3) != 0,
                 ($urandom % 3) != 0,
                 5'($urandom),
                 5'($urandom),
                 ($urandom % 40) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule